// File: doc/BRIEF.md
# NAND Flash Word-Register Bridge

This block lets a processor run a raw 8-bit NAND flash device through a single 32-bit word. Every processor write is one complete instruction: a three-bit kind field picks a command-latch, address-latch or data-write cycle, or arms read mode. A separate bit sets chip enable, and a byte field carries the value for the I/O bus. The bridge turns each write into one timed strobe on the NAND pins. The low time of the strobe and the hold time after it are set by parameters.

Reads are of two kinds. A read of the control address returns the device busy flag, taken from the ready/busy line through a synchroniser. A read of the data address performs one read strobe once read mode has been armed, and returns the byte captured from the flash. Any number of such reads may follow one arm write, and each returns the next byte from the device.

The processor side is a valid/ready request channel and a valid/ready response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a strobe sequence is running and while a read response is waiting. A response stays valid with constant data until `rsp_ready` takes it, so no access is ever lost. Writes are decoded the same way at either address. Only reads return a response.

Top module: `nand_word_bridge`

## Requirements
- R1: Word bits 30:28 hold the cycle kind: 0 is a command cycle, 1 an address cycle, 2 arms read mode, 3 a data-write cycle. During the strobe of a command cycle `nand_cle` is 1 and `nand_ale` is 0. For an address cycle `nand_ale` is 1 and `nand_cle` is 0. For a data-write cycle both are 0, and the two are never high together.
- R2: `nand_ce_n` is the inverse of bit 31 of the most recently accepted write of kind 0 to 3. It is 1 after reset.
- R3: A write of kind 0, 1 or 3 produces exactly one low pulse on `nand_we_n` and no pulse on `nand_re_n`. Bits 23:16 of the word appear on `nand_io_out` with `nand_io_oe` high, and stay constant for as long as `nand_io_oe` stays high.
- R4: `nand_we_n` stays low for exactly PULSE_LOW clocks. `nand_io_oe` is high for one clock before the fall and for HOLD clocks after the rise, which is PULSE_LOW+HOLD+1 clocks in total.
- R5: After a kind-2 write, each read of the data address (`req_addr`=1) produces one low pulse on `nand_re_n` of PULSE_LOW clocks. The response carries the byte present on `nand_io_in` at the rising edge in bits 23:16, with every other bit 0. Reads that follow each other return successive device bytes with no new arm write.
- R6: A kind-2 write itself produces no strobe. A data-address read while read mode is not armed returns 0 and produces no strobe. Read mode is off after reset and after any write of kind 0, 1 or 3.
- R7: A read of the control address (`req_addr`=0) produces no strobe. Its response has bit 15 set to 1 when `nand_rb_n` has been low (busy) for at least SYNC_STAGES+1 clocks, and set to 0 when it has been high for that long. Every other bit is 0.
- R8: A write whose kind is 4 to 7 is ignored. It produces no strobe, leaves `nand_ce_n` unchanged and leaves read mode unchanged.
- R9: `req_ready` is low from the accepting edge until the strobe sequence ends, and while a response is held. A held response keeps `rsp_valid` high and `rsp_rdata` constant until `rsp_ready` is high.
- R10: `nand_io_oe` is never high while `nand_re_n` is low, and `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write word, 0 = read |
| req_addr | input | 1 | 0 = control/status address, 1 = data read address |
| req_wdata | input | 32 | Write word (kind, chip enable, byte) |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_rdata | output | 32 | Read response word |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus output value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input value |
| nand_rb_n | input | 1 | Ready/busy line, low = busy |

## Verification
The assertions assume that the processor keeps `req_valid` and the request fields stable for the whole cycle in which they are presented. They also assume that `rsp_ready` is driven from the processor side only. The pulse-width checks further assume that `rst_n` is held low long enough for every pin to reach its idle level. The bench drives all request signals on the falling clock edge and drops `req_valid` right after each accept. It changes `nand_rb_n` only between accesses, and holds reset for several clocks. The device model places a new pattern byte on `nand_io_in` only after each rising edge of the read strobe, which keeps the input within the sampling window that the capture edge expects.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int KIND_LSB = 28;
  localparam int KIND_W   = 3;
  localparam int CE_BIT   = 31;
  localparam int BYTE_LSB = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [KIND_W-1:0] KIND_CMD  = 3'd0;
  localparam logic [KIND_W-1:0] KIND_ADDR = 3'd1;
  localparam logic [KIND_W-1:0] KIND_ARM  = 3'd2;
  localparam logic [KIND_W-1:0] KIND_DATA = 3'd3;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_DATA, OP_READ} op_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_t;
endpackage

// File: rtl/nwb_sync.sv
module nwb_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nwb_strobe_seq.sv
module nwb_strobe_seq
  import nwb_pkg::*;
#(
  parameter int PULSE_LOW = 3,
  parameter int HOLD      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_t               op,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [BYTE_W-1:0] io_in,
  output logic              busy,
  output logic              finish_read,
  output logic [BYTE_W-1:0] rbyte,
  output logic              we_n,
  output logic              re_n,
  output logic              cle,
  output logic              ale,
  output logic [BYTE_W-1:0] io_out,
  output logic              io_oe
);
  localparam int MAXC = (PULSE_LOW > HOLD) ? PULSE_LOW : HOLD;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] LOW_LAST  = CW'(PULSE_LOW - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD - 1);

  phase_t            phase;
  logic [CW-1:0]     cnt;
  op_t               op_q;
  logic [BYTE_W-1:0] byte_q;
  logic              is_rd, active, last_hold;

  assign is_rd     = (op_q == OP_READ);
  assign active    = (phase != PH_IDLE);
  assign last_hold = (phase == PH_HOLD) && (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      op_q   <= OP_DATA;
      byte_q <= '0;
      rbyte  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SETUP;
          op_q   <= op;
          byte_q <= wbyte;
        end
        PH_SETUP: begin
          phase <= PH_LOW;
          cnt   <= '0;
        end
        PH_LOW: if (cnt == LOW_LAST) begin
          phase <= PH_HOLD;
          cnt   <= '0;
          if (is_rd) rbyte <= io_in;
        end else cnt <= cnt + 1'b1;
        PH_HOLD: if (last_hold) phase <= PH_IDLE;
                 else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy        = active;
  assign finish_read = last_hold && is_rd;
  assign we_n        = !((phase == PH_LOW) && !is_rd);
  assign re_n        = !((phase == PH_LOW) && is_rd);
  assign cle         = active && (op_q == OP_CMD);
  assign ale         = active && (op_q == OP_ADDR);
  assign io_oe       = active && !is_rd;
  assign io_out      = byte_q;
endmodule

// File: rtl/nand_word_bridge.sv
module nand_word_bridge
  import nwb_pkg::*;
#(
  parameter int PULSE_LOW   = 3,
  parameter int HOLD        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [BYTE_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [BYTE_W-1:0] nand_io_in,
  input  logic              nand_rb_n
);
  logic              accept, wr_known, seq_start, seq_busy, seq_fin_rd;
  logic              ce_q, armed_q, rb_sync;
  logic [KIND_W-1:0] kind;
  logic [BYTE_W-1:0] seq_rbyte;
  op_t               seq_op;

  assign accept    = req_valid && req_ready;
  assign kind      = req_wdata[KIND_LSB +: KIND_W];
  assign wr_known  = accept && req_write && (kind <= KIND_DATA);
  assign req_ready = !seq_busy && !rsp_valid;

  always_comb begin
    seq_op    = OP_DATA;
    seq_start = 1'b0;
    if (wr_known && kind != KIND_ARM) begin
      seq_start = 1'b1;
      unique case (kind)
        KIND_CMD:  seq_op = OP_CMD;
        KIND_ADDR: seq_op = OP_ADDR;
        default:   seq_op = OP_DATA;
      endcase
    end else if (accept && !req_write && req_addr && armed_q) begin
      seq_start = 1'b1;
      seq_op    = OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr_known) begin
      ce_q    <= req_wdata[CE_BIT];
      armed_q <= (kind == KIND_ARM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept && !req_write && !req_addr) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
        rsp_rdata[BUSY_BIT] <= !rb_sync;
      end else if (accept && !req_write && !armed_q) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
      end
      if (seq_fin_rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
        rsp_rdata[BYTE_LSB +: BYTE_W] <= seq_rbyte;
      end
    end
  end

  assign nand_ce_n = !ce_q;

  nwb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rb_sync)
  );

  nwb_strobe_seq #(.PULSE_LOW(PULSE_LOW), .HOLD(HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .op(seq_op),
    .wbyte(req_wdata[BYTE_LSB +: BYTE_W]), .io_in(nand_io_in),
    .busy(seq_busy), .finish_read(seq_fin_rd), .rbyte(seq_rbyte),
    .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
    .io_out(nand_io_out), .io_oe(nand_io_oe)
  );
endmodule

// File: rtl/nwb_checker.sv
module nwb_checker #(
  parameter int PULSE_LOW = 3,
  parameter int HOLD      = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic [7:0]  nand_io_out,
  input logic        nand_io_oe
);
  logic [15:0] we_run, re_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      re_run <= '0;
    end else begin
      we_run <= nand_we_n ? '0 : we_run + 1'b1;
      re_run <= nand_re_n ? '0 : re_run + 1'b1;
    end
  end

  assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_io_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nand_io_oe) && nand_io_oe) |-> $stable(nand_io_out));
  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (we_run == 16'(PULSE_LOW)));
  assert_setup_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> $past(nand_io_oe));
  assert_low_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_io_oe);
  assert_re_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> (re_run == 16'(PULSE_LOW)));
  assert_rsp_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~32'h00FF_8000) == 32'h0));
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !req_ready);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_no_drive_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
endmodule

bind nand_word_bridge nwb_checker #(.PULSE_LOW(PULSE_LOW), .HOLD(HOLD)) u_nwb_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe)
);

// File: tb/nand_word_bridge_bench.sv
module nand_word_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 3;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        nand_rb_n = 1'b1;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;

  int checks = 0, fails = 0;
  int nand_idx = 0;
  int we_falls = 0, re_falls = 0, we_low = 0, re_low = 0, oe_cyc = 0, oe_in_rd = 0;
  logic last_cle, last_ale, last_oe;
  logic [7:0] last_io;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_word_bridge #(.PULSE_LOW(PL), .HOLD(HD)) u_nand_word_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 91) % 256);
  endfunction

  assign nand_io_in = pat(nand_idx);

  always @(posedge nand_re_n) if (rst_n) nand_idx++;
  always @(negedge nand_we_n) if (rst_n) begin
    we_falls++;
    last_cle = nand_cle; last_ale = nand_ale; last_oe = nand_io_oe; last_io = nand_io_out;
  end
  always @(negedge nand_re_n) if (rst_n) re_falls++;
  always @(posedge clk) if (rst_n) begin
    if (nand_we_n === 1'b0) we_low++;
    if (nand_re_n === 1'b0) re_low++;
    if (nand_io_oe === 1'b1) oe_cyc++;
    if (nand_io_oe === 1'b1 && nand_re_n === 1'b0) oe_in_rd++;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 1'b0; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic logic [31:0] word(input logic ce, input logic [2:0] k, input logic [7:0] b);
    return {ce, k, 4'h0, b, 16'h0};
  endfunction

  task automatic write_and_check(input logic ce, input logic [2:0] k, input logic [7:0] b);
    int wf, rf, wl, oc;
    wf = we_falls; rf = re_falls; wl = we_low; oc = oe_cyc;
    do_write(word(ce, k, b));
    chk(we_falls == wf + 1, "R3 one write strobe", 32'(we_falls - wf), 1);
    chk(re_falls == rf, "R3 no read strobe", 32'(re_falls - rf), 0);
    chk(last_cle == (k == 3'd0) && last_ale == (k == 3'd1), "R1 latch pins",
        {30'h0, last_cle, last_ale}, {30'h0, k == 3'd0, k == 3'd1});
    chk(last_oe && last_io == b, "R3 bus byte", {23'h0, last_oe, last_io}, {23'h0, 1'b1, b});
    chk(we_low == wl + PL, "R4 WE low width", 32'(we_low - wl), PL);
    chk(oe_cyc == oc + PL + HD + 1, "R4 drive window", 32'(oe_cyc - oc), PL + HD + 1);
    chk(nand_ce_n == !ce, "R2 chip enable", 32'(nand_ce_n), 32'(!ce));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k_exp;
    int wf, rf, rl, oir;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe && !nand_cle && !nand_ale,
        "R2 reset pins", {26'h0, nand_ce_n, nand_we_n, nand_re_n, nand_io_oe, nand_cle, nand_ale},
        32'h38);
    chk(req_ready && !rsp_valid, "R9 reset handshake", {30'h0, req_ready, rsp_valid}, 32'h2);

    // R1 R2 R3 R4: sweep every byte for each strobe kind and both chip-enable values
    for (int kk = 0; kk < 3; kk++)
      for (int ce = 0; ce < 2; ce++)
        for (int b = 0; b < 256; b++)
          write_and_check(ce[0], (kk == 2) ? 3'd3 : 3'(kk), 8'(b));

    // R9: stall right after a strobe write is taken
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 1'b0; req_wdata = word(1'b1, 3'd3, 8'h5A);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 stall during strobe", 32'(req_ready), 0);
    while (!req_ready) @(negedge clk);

    // R6: unarmed data read after a data write
    rf = re_falls;
    do_read(1'b1, d);
    chk(d == 32'h0 && re_falls == rf, "R6 unarmed read", d, 0);

    // R6: arm write makes no strobe
    wf = we_falls; rf = re_falls;
    do_write(word(1'b1, 3'd2, 8'hFF));
    chk(we_falls == wf && re_falls == rf, "R6 arm no strobe", 32'(we_falls - wf), 0);
    chk(nand_ce_n == 1'b0, "R2 arm sets enable", 32'(nand_ce_n), 0);

    // R5: streaming reads
    k_exp = nand_idx;
    for (int i = 0; i < 16; i++) begin
      rf = re_falls; rl = re_low; oir = oe_in_rd;
      do_read(1'b1, d);
      chk(d == {8'h0, pat(k_exp), 16'h0}, "R5 read byte", d, {8'h0, pat(k_exp), 16'h0});
      chk(re_falls == rf + 1 && re_low == rl + PL, "R5 RE pulse", 32'(re_low - rl), PL);
      chk(oe_in_rd == oir, "R10 bus released", 32'(oe_in_rd - oir), 0);
      k_exp++;
    end

    // R8: ignored kinds keep enable, read mode and pins
    for (int kk = 4; kk < 8; kk++) begin
      wf = we_falls; rf = re_falls;
      do_write(word(1'b0, 3'(kk), 8'(kk * 17)));
      chk(we_falls == wf && re_falls == rf, "R8 no strobe", 32'(we_falls - wf), 0);
      chk(nand_ce_n == 1'b0, "R8 enable kept", 32'(nand_ce_n), 0);
    end
    do_read(1'b1, d);
    chk(d == {8'h0, pat(k_exp), 16'h0}, "R8 read mode kept", d, {8'h0, pat(k_exp), 16'h0});
    k_exp++;

    // R7: busy status
    rf = re_falls;
    nand_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    do_read(1'b0, d);
    chk(d == 32'h0000_8000, "R7 busy set", d, 32'h8000);
    nand_rb_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(1'b0, d);
    chk(d == 32'h0, "R7 busy clear", d, 0);
    chk(re_falls == rf, "R7 status no strobe", 32'(re_falls - rf), 0);

    // R9: response back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == d && !req_ready, "R9 held response", rsp_rdata, d);
    end
    chk(d == {8'h0, pat(k_exp), 16'h0}, "R9 held data", d, {8'h0, pat(k_exp), 16'h0});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 response taken", {30'h0, rsp_valid, req_ready}, 32'h1);

    // R6: command write disarms; R2 enable cleared
    write_and_check(1'b0, 3'd0, 8'h70);
    rf = re_falls;
    do_read(1'b1, d);
    chk(d == 32'h0 && re_falls == rf, "R6 disarmed by command", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule